// File: doc/BRIEF.md
# Interference Estimator with Bit-Variance Flag

This block samples two 4-bit received nibbles and a 2-bit operation code. From them it forms two result nibbles. The first result is the bitwise exclusive-or of the two inputs. The second result comes from a small arithmetic unit that passes either input through, subtracts the second input from the first, or adds the two.

Each result is compared bit by bit against a reference nibble. The first result is compared with the first input and the second result with the second input. When either result differs from its reference in more than half of its bit positions, the block raises an interference flag. A valid strobe marks the cycle in which all outputs are updated.

All outputs are registered and appear one clock after the accepted input.

Top module: `intf_estimator`

## Requirements
- R1: An active-low synchronous reset (rst_n=0 at a rising edge) clears res_a, res_b, intf_flag and out_valid to 0.
- R2: out_valid is 1 in the cycle after a rising edge at which in_valid was 1, and 0 in the cycle after a rising edge at which in_valid was 0.
- R3: When in_valid=1, res_a becomes pat_a XOR pat_b on the next clock.
- R4: With op=2'b00 (op[1] is the first control bit, op[0] the second), res_b becomes pat_a.
- R5: With op=2'b01, res_b becomes pat_b.
- R6: With op=2'b10, res_b becomes (pat_a - pat_b) mod 16, and the borrow is dropped.
- R7: With op=2'b11, res_b becomes (pat_a + pat_b) mod 16, and the carry is dropped.
- R8: intf_flag is 1 when popcount(res_a XOR pat_a) >= 3 or popcount(res_b XOR pat_b) >= 3. This is the strict greater-than-50% threshold for 4 bits. A count of exactly 2 (50%) does not raise the flag.
- R9: When in_valid=0, res_a, res_b and intf_flag keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept the inputs this cycle |
| pat_a | input | 4 | First received nibble |
| pat_b | input | 4 | Second received nibble |
| op | input | 2 | Arithmetic select for res_b |
| res_a | output | 4 | Exclusive-or result |
| res_b | output | 4 | Arithmetic unit result |
| intf_flag | output | 1 | Bit variance above half on either result |
| out_valid | output | 1 | Outputs updated this cycle |

## Verification
The datapath has only one register stage. A wrong operation decode or a wrong wrap-around would show up on res_b in the very cycle after the bad vector. An off-by-one in the threshold comparison would show up on intf_flag in that same cycle, so every fault is visible one clock after its cause. Faults in the hold path show only when in_valid is low, so the stimulus interleaves idle cycles and checks that the previous outputs remain.

// File: rtl/intf_estimator.sv
module intf_estimator #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] pat_a,
  input  logic [W-1:0] pat_b,
  input  logic [1:0]   op,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         intf_flag,
  output logic         out_valid
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  x_nxt, b_nxt;
  logic [CW-1:0] cnt_a, cnt_b;
  logic          flag_nxt;

  assign x_nxt = pat_a ^ pat_b;

  always_comb begin
    unique case (op)
      2'b00: b_nxt = pat_a;
      2'b01: b_nxt = pat_b;
      2'b10: b_nxt = pat_a - pat_b;
      default: b_nxt = pat_a + pat_b;
    endcase
  end

  assign cnt_a = CW'($countones(x_nxt ^ pat_a));
  assign cnt_b = CW'($countones(b_nxt ^ pat_b));
  assign flag_nxt = (2 * cnt_a > CW'(W)) || (2 * cnt_b > CW'(W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_a     <= '0;
      res_b     <= '0;
      intf_flag <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_a     <= x_nxt;
        res_b     <= b_nxt;
        intf_flag <= flag_nxt;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (res_a == '0 && res_b == '0 && !intf_flag && !out_valid));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3
  xor_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_a ^ $past(pat_b)) == $past(pat_a));

  // R5
  pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01) |=> res_b == $past(pat_b));

  // R7
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=> W'(res_b - $past(pat_b)) == $past(pat_a));

  // R8
  flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $countones(res_b ^ $past(pat_b)) < 3
               && $countones(res_a ^ $past(pat_a)) < 3) |-> !intf_flag);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_a) && $stable(res_b) && $stable(intf_flag)));
endmodule

// File: tb/intf_estimator_tb.sv
module intf_estimator_tb;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [3:0] pat_a = 0, pat_b = 0;
  logic [1:0] op = 0;
  logic [3:0] res_a, res_b;
  logic intf_flag, out_valid;
  int vectors = 0, errors = 0;
  logic [3:0] ea = 0, eb = 0;
  logic ef = 0;

  always #2 clk = ~clk;

  intf_estimator u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pat_a(pat_a), .pat_b(pat_b), .op(op), .res_a(res_a), .res_b(res_b),
    .intf_flag(intf_flag), .out_valid(out_valid));

  function automatic logic [3:0] ref_b(input logic [3:0] a, b, input logic [1:0] o);
    case (o)
      2'b00: return a;
      2'b01: return b;
      2'b10: return 4'((a + 16) - b);
      default: return 4'(a + b);
    endcase
  endfunction

  function automatic int pc(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += v[i];
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, b, input logic [1:0] o, input logic v);
    @(negedge clk);
    pat_a = a; pat_b = b; op = o; in_valid = v;
    if (v) begin
      ea = a ^ b;
      eb = ref_b(a, b, o);
      ef = (pc(ea ^ a) >= 3) || (pc(eb ^ b) >= 3);
    end
    @(negedge clk);
    chk("R2 out_valid", out_valid, v);
    chk(v ? "R3 res_a" : "R9 res_a hold", res_a, ea);
    case (o)
      2'b00: chk(v ? "R4 res_b" : "R9 res_b hold", res_b, eb);
      2'b01: chk(v ? "R5 res_b" : "R9 res_b hold", res_b, eb);
      2'b10: chk(v ? "R6 res_b" : "R9 res_b hold", res_b, eb);
      default: chk(v ? "R7 res_b" : "R9 res_b hold", res_b, eb);
    endcase
    chk(v ? "R8 intf_flag" : "R9 flag hold", intf_flag, ef);
    in_valid = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 res_a", res_a, 0);
    chk("R1 res_b", res_b, 0);
    chk("R1 flag", intf_flag, 0);
    chk("R1 valid", out_valid, 0);
    rst_n = 1;
    apply(4'h3, 4'h5, 2'b10, 1);
    apply(4'hF, 4'h1, 2'b11, 1);
    apply(4'h0, 4'hF, 2'b01, 1);
    apply(4'hF, 4'h0, 2'b00, 1);
    apply(4'h3, 4'h0, 2'b00, 1);
    apply(4'h7, 4'h0, 2'b00, 1);
    apply(4'h0, 4'h0, 2'b10, 1);
    apply(4'hA, 4'h5, 2'b11, 0);
    for (int i = 0; i < 400; i++)
      apply(4'($urandom), 4'($urandom), 2'($urandom), ($urandom % 4) != 0);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 res_b after reset", res_b, 0);
    chk("R1 valid after reset", out_valid, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule